// File: doc/BRIEF.md
# Address Translation Request Classifier

This block sits at the entry of an address translation unit. It decides what kind of access each incoming request is before any table walk begins. A request carries an effective address, an access kind (read, write or execute), the two relocation enables (one for instruction fetch, one for data) and the current partition and process identifiers. One clock after the request, the block returns exactly one of three outcomes.

A **real-mode** outcome carries a physical address made by clearing the top address bits, with read, write and execute all granted. A **walk** outcome hands the walker a (partition, process) identifier pair and the effective address with its quadrant bits removed. A **segment fault** outcome reports an illegal address quadrant, split into an instruction flavour and a data flavour.

The quadrant is effective-address bits 63:62. It selects the process identifier to use: the live register for applications, zero for the operating system, and none for the two illegal quadrants.

Top module: `xlat_front`

## Requirements
- R1: Access kind is encoded 0 = read, 1 = write, 2 = execute, 3 = treated as a data access. An execute request with `instRelocOn` low, or any other request with `dataRelocOn` low, produces a real-mode response, whatever its quadrant. The relocation bit that does not match the access kind has no effect.
- R2: A real-mode response sets `realAddr` to the effective address with its top `REAL_CLR_W` (default 4) bits cleared, and raises `grantRead`, `grantWrite` and `grantExec`.
- R3: A relocated request in quadrant 0 (bits 63:62 = 2'b00) produces a walk response with `walkLpid` = `partIdReg` and `walkPid` = `procIdReg`.
- R4: A relocated request in quadrant 3 (bits 63:62 = 2'b11) produces a walk response with `walkLpid` = `partIdReg` and `walkPid` = 0.
- R5: A relocated request in quadrant 1 or 2 produces a segment-fault response and no walk.
- R6: A segment fault on an execute request sets `segIsInstr` = 1 and leaves `faultAddr` = 0.
- R7: A segment fault on a data request (kinds 0, 1, 3) sets `segIsInstr` = 0 and `faultAddr` = the full effective address.
- R8: A walk response sets `walkAddr` to the effective address with bits 63:62 cleared, and sets `walkAcc` to the request's access kind.
- R9: `rspValid` rises exactly one cycle after each cycle with `reqValid` high and is low otherwise. While it is high, exactly one of `rspReal`, `rspWalk` and `rspSeg` is set.
- R10: After reset, `rspValid`, `rspReal`, `rspWalk` and `rspSeg` are low.
- R11: In a response, the fields of the outcomes not taken read zero. These are `realAddr` and the grants unless real mode, `walkAddr`/`walkAcc`/`walkLpid`/`walkPid` unless walk, and `segIsInstr`/`faultAddr` unless a segment fault of that flavour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| effAddr | input | ADDR_W | Effective address |
| accType | input | 2 | Access kind |
| instRelocOn | input | 1 | Instruction relocation enable |
| dataRelocOn | input | 1 | Data relocation enable |
| partIdReg | input | LPID_W | Partition identifier |
| procIdReg | input | PID_W | Process identifier |
| rspValid | output | 1 | Response present |
| rspReal | output | 1 | Outcome: real mode |
| rspWalk | output | 1 | Outcome: walk |
| rspSeg | output | 1 | Outcome: segment fault |
| grantRead | output | 1 | Read granted (real mode) |
| grantWrite | output | 1 | Write granted (real mode) |
| grantExec | output | 1 | Execute granted (real mode) |
| realAddr | output | ADDR_W | Real-mode physical address |
| walkAddr | output | ADDR_W | Quadrant-stripped address for the walker |
| walkAcc | output | 2 | Access kind forwarded to the walker |
| walkLpid | output | LPID_W | Partition identifier for the walk |
| walkPid | output | PID_W | Process identifier for the walk |
| segIsInstr | output | 1 | Segment fault is of the instruction flavour |
| faultAddr | output | ADDR_W | Captured address of a data segment fault |

## Verification
The hardest case to reach is the one where the relocation bit that does not belong to the access kind must be ignored. An example is a data request in an illegal quadrant with instruction relocation off, which must still fault and capture its address. The bench reaches it by sweeping every access kind against all four relocation-bit combinations and all four quadrants. It repeats the sweep over several address and identifier patterns, so every mismatched pairing is driven and the outcome and zeroed fields are checked each time.

// File: rtl/xlat_front_pkg.sv
package xlat_front_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    QUAD_APP  = 2'd0,
    QUAD_ILL1 = 2'd1,
    QUAD_ILL2 = 2'd2,
    QUAD_OS   = 2'd3
  } quad_e;

  // strobes from the classifier to the response registers
  typedef struct packed {
    logic loadStb;   // capture a new response
    logic realStb;   // outcome: real mode
    logic walkStb;   // outcome: walk
    logic segStb;    // outcome: segment fault
    logic pidKeep;   // use the live process identifier
    logic segInstr;  // fault flavour is instruction
  } ctrlStrobe_t;

endpackage

// File: rtl/xlat_front_ctrl.sv
module xlat_front_ctrl
  import xlat_front_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  accType,
  input  logic        instRelocOn,
  input  logic        dataRelocOn,
  input  logic [1:0]  quadBits,
  output ctrlStrobe_t stb
);

  acc_e  accKind;
  quad_e quadSel;
  logic  isExec;
  logic  relocOn;

  assign accKind = acc_e'(accType);
  assign quadSel = quad_e'(quadBits);
  assign isExec  = (accKind == ACC_EXEC);
  assign relocOn = isExec ? instRelocOn : dataRelocOn;

  always_comb begin
    stb          = '0;
    stb.loadStb  = reqValid;
    stb.segInstr = isExec;
    if (!relocOn) begin
      stb.realStb = 1'b1;
    end else begin
      unique case (quadSel)
        QUAD_APP: begin
          stb.walkStb = 1'b1;
          stb.pidKeep = 1'b1;
        end
        QUAD_OS:   stb.walkStb = 1'b1;
        QUAD_ILL1,
        QUAD_ILL2: stb.segStb  = 1'b1;
        default:   stb.segStb  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/xlat_front_dpath.sv
module xlat_front_dpath
  import xlat_front_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LPID_W     = 12,
  parameter int PID_W      = 20,
  parameter int REAL_CLR_W = 4,
  parameter int QUAD_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        accType,
  input  logic [LPID_W-1:0] partIdReg,
  input  logic [PID_W-1:0]  procIdReg,
  output logic              rspValid,
  output logic              rspReal,
  output logic              rspWalk,
  output logic              rspSeg,
  output logic              grantRead,
  output logic              grantWrite,
  output logic              grantExec,
  output logic [ADDR_W-1:0] realAddr,
  output logic [ADDR_W-1:0] walkAddr,
  output logic [1:0]        walkAcc,
  output logic [LPID_W-1:0] walkLpid,
  output logic [PID_W-1:0]  walkPid,
  output logic              segIsInstr,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int REAL_KEEP_W = ADDR_W - REAL_CLR_W;
  localparam int WALK_KEEP_W = ADDR_W - QUAD_W;

  logic [ADDR_W-1:0] realMask;
  logic [ADDR_W-1:0] walkMask;

  // keep-masks built bit by bit
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign realMask[b] = (b < REAL_KEEP_W);
    assign walkMask[b] = (b < WALK_KEEP_W);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspReal    <= 1'b0;
      rspWalk    <= 1'b0;
      rspSeg     <= 1'b0;
      grantRead  <= 1'b0;
      grantWrite <= 1'b0;
      grantExec  <= 1'b0;
      realAddr   <= '0;
      walkAddr   <= '0;
      walkAcc    <= '0;
      walkLpid   <= '0;
      walkPid    <= '0;
      segIsInstr <= 1'b0;
      faultAddr  <= '0;
    end else begin
      rspValid <= stb.loadStb;
      if (stb.loadStb) begin
        rspReal    <= stb.realStb;
        rspWalk    <= stb.walkStb;
        rspSeg     <= stb.segStb;
        grantRead  <= stb.realStb;
        grantWrite <= stb.realStb;
        grantExec  <= stb.realStb;
        realAddr   <= stb.realStb ? (effAddr & realMask) : '0;
        walkAddr   <= stb.walkStb ? (effAddr & walkMask) : '0;
        walkAcc    <= stb.walkStb ? accType : 2'b00;
        walkLpid   <= stb.walkStb ? partIdReg : '0;
        walkPid    <= (stb.walkStb && stb.pidKeep) ? procIdReg : '0;
        segIsInstr <= stb.segStb && stb.segInstr;
        faultAddr  <= (stb.segStb && !stb.segInstr) ? effAddr : '0;
      end
    end
  end

endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xlat_front_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LPID_W     = 12,
  parameter int PID_W      = 20,
  parameter int REAL_CLR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        accType,
  input  logic              instRelocOn,
  input  logic              dataRelocOn,
  input  logic [LPID_W-1:0] partIdReg,
  input  logic [PID_W-1:0]  procIdReg,
  output logic              rspValid,
  output logic              rspReal,
  output logic              rspWalk,
  output logic              rspSeg,
  output logic              grantRead,
  output logic              grantWrite,
  output logic              grantExec,
  output logic [ADDR_W-1:0] realAddr,
  output logic [ADDR_W-1:0] walkAddr,
  output logic [1:0]        walkAcc,
  output logic [LPID_W-1:0] walkLpid,
  output logic [PID_W-1:0]  walkPid,
  output logic              segIsInstr,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int QUAD_W = 2;

  ctrlStrobe_t stb;

  xlat_front_ctrl ctrl_i (
    .reqValid    (reqValid),
    .accType     (accType),
    .instRelocOn (instRelocOn),
    .dataRelocOn (dataRelocOn),
    .quadBits    (effAddr[ADDR_W-1 -: QUAD_W]),
    .stb         (stb)
  );

  xlat_front_dpath #(
    .ADDR_W     (ADDR_W),
    .LPID_W     (LPID_W),
    .PID_W      (PID_W),
    .REAL_CLR_W (REAL_CLR_W),
    .QUAD_W     (QUAD_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .effAddr    (effAddr),
    .accType    (accType),
    .partIdReg  (partIdReg),
    .procIdReg  (procIdReg),
    .rspValid   (rspValid),
    .rspReal    (rspReal),
    .rspWalk    (rspWalk),
    .rspSeg     (rspSeg),
    .grantRead  (grantRead),
    .grantWrite (grantWrite),
    .grantExec  (grantExec),
    .realAddr   (realAddr),
    .walkAddr   (walkAddr),
    .walkAcc    (walkAcc),
    .walkLpid   (walkLpid),
    .walkPid    (walkPid),
    .segIsInstr (segIsInstr),
    .faultAddr  (faultAddr)
  );

endmodule

// File: rtl/xlat_front_chk.sv
module xlat_front_chk #(
  parameter int ADDR_W     = 64,
  parameter int PID_W      = 20,
  parameter int REAL_CLR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic [1:0]        accType,
  input logic              instRelocOn,
  input logic              dataRelocOn,
  input logic              rspValid,
  input logic              rspReal,
  input logic              rspWalk,
  input logic              rspSeg,
  input logic              grantRead,
  input logic              grantWrite,
  input logic              grantExec,
  input logic [ADDR_W-1:0] realAddr,
  input logic [PID_W-1:0]  walkPid,
  input logic              segIsInstr,
  input logic [ADDR_W-1:0] faultAddr
);

  logic reqExec;
  logic reqReloc;
  logic [1:0] reqQuad;

  assign reqExec  = (accType == 2'd2);
  assign reqReloc = reqExec ? instRelocOn : dataRelocOn;
  assign reqQuad  = effAddr[ADDR_W-1 -: 2];

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({rspReal, rspWalk, rspSeg}));

  // R1
  real_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReloc) |=> rspReal);

  // R2
  real_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReal) |->
      (grantRead && grantWrite && grantExec &&
       realAddr[ADDR_W-1 -: REAL_CLR_W] == '0));

  // R4
  os_pid_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReloc && reqQuad == 2'b11) |=> (rspWalk && walkPid == '0));

  // R5
  illegal_quad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReloc && (reqQuad == 2'b01 || reqQuad == 2'b10)) |=> rspSeg);

  // R7
  data_fault_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReloc && !reqExec && (reqQuad == 2'b01 || reqQuad == 2'b10))
      |=> (!segIsInstr && faultAddr == $past(effAddr)));

  // R6
  instr_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspSeg && segIsInstr) |-> (faultAddr == '0));

endmodule

bind xlat_front xlat_front_chk #(
  .ADDR_W     (ADDR_W),
  .PID_W      (PID_W),
  .REAL_CLR_W (REAL_CLR_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .effAddr     (effAddr),
  .accType     (accType),
  .instRelocOn (instRelocOn),
  .dataRelocOn (dataRelocOn),
  .rspValid    (rspValid),
  .rspReal     (rspReal),
  .rspWalk     (rspWalk),
  .rspSeg      (rspSeg),
  .grantRead   (grantRead),
  .grantWrite  (grantWrite),
  .grantExec   (grantExec),
  .realAddr    (realAddr),
  .walkPid     (walkPid),
  .segIsInstr  (segIsInstr),
  .faultAddr   (faultAddr)
);

// File: tb/xlat_front_tb_top.sv
module xlat_front_tb_top;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 64;
  localparam int LPID_W = 12;
  localparam int PID_W  = 20;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [ADDR_W-1:0] effAddr;
  logic [1:0]        accType;
  logic              instRelocOn;
  logic              dataRelocOn;
  logic [LPID_W-1:0] partIdReg;
  logic [PID_W-1:0]  procIdReg;
  logic              rspValid, rspReal, rspWalk, rspSeg;
  logic              grantRead, grantWrite, grantExec;
  logic [ADDR_W-1:0] realAddr, walkAddr, faultAddr;
  logic [1:0]        walkAcc;
  logic [LPID_W-1:0] walkLpid;
  logic [PID_W-1:0]  walkPid;
  logic              segIsInstr;

  int checks   = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  xlat_front dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .effAddr(effAddr),
    .accType(accType), .instRelocOn(instRelocOn), .dataRelocOn(dataRelocOn),
    .partIdReg(partIdReg), .procIdReg(procIdReg), .rspValid(rspValid),
    .rspReal(rspReal), .rspWalk(rspWalk), .rspSeg(rspSeg),
    .grantRead(grantRead), .grantWrite(grantWrite), .grantExec(grantExec),
    .realAddr(realAddr), .walkAddr(walkAddr), .walkAcc(walkAcc),
    .walkLpid(walkLpid), .walkPid(walkPid), .segIsInstr(segIsInstr),
    .faultAddr(faultAddr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [1:0] acc, input bit ir, input bit dr,
                        input logic [63:0] addr, input logic [11:0] lp,
                        input logic [19:0] pd);
    bit isExec, reloc, expReal, expWalk, expSeg;
    logic [1:0] q;
    logic [63:0] expRealAddr, expWalkAddr, expFault;
    logic [19:0] expPid;
    isExec  = (acc == 2'd2);
    reloc   = isExec ? ir : dr;
    q       = addr[63:62];
    expReal = !reloc;
    expWalk = reloc && (q == 2'b00 || q == 2'b11);
    expSeg  = reloc && (q == 2'b01 || q == 2'b10);
    expRealAddr = expReal ? (addr & 64'h0FFF_FFFF_FFFF_FFFF) : 64'd0;
    expWalkAddr = expWalk ? {2'b00, addr[61:0]} : 64'd0;
    expPid      = (expWalk && q == 2'b00) ? pd : 20'd0;
    expFault    = (expSeg && !isExec) ? addr : 64'd0;

    @(negedge clk);
    reqValid = 1'b1; accType = acc; instRelocOn = ir; dataRelocOn = dr;
    effAddr = addr; partIdReg = lp; procIdReg = pd;
    @(negedge clk);
    reqValid = 1'b0;
    // R9 response one cycle later, single outcome
    check(rspValid == 1'b1, "R9 rspValid", {63'd0, rspValid}, 64'd1);
    // R1 real-mode selection
    check(rspReal == expReal, "R1 rspReal", {63'd0, rspReal}, {63'd0, expReal});
    // R5 illegal quadrant fault
    check(rspSeg == expSeg, "R5 rspSeg", {63'd0, rspSeg}, {63'd0, expSeg});
    // R3 walk outcome
    check(rspWalk == expWalk, "R3 rspWalk", {63'd0, rspWalk}, {63'd0, expWalk});
    // R2 real address and grants (R11 zero otherwise)
    check(realAddr == expRealAddr, "R2 realAddr", realAddr, expRealAddr);
    check({grantRead, grantWrite, grantExec} == {3{expReal}}, "R2 grants",
          {61'd0, grantRead, grantWrite, grantExec}, {61'd0, {3{expReal}}});
    // R8 walk address and access kind (R11 zero otherwise)
    check(walkAddr == expWalkAddr, "R8 walkAddr", walkAddr, expWalkAddr);
    check(walkAcc == (expWalk ? acc : 2'd0), "R8 walkAcc",
          {62'd0, walkAcc}, {62'd0, expWalk ? acc : 2'd0});
    // R3/R4 identifiers
    check(walkLpid == (expWalk ? lp : 12'd0), "R3 walkLpid",
          {52'd0, walkLpid}, {52'd0, expWalk ? lp : 12'd0});
    check(walkPid == expPid, (q == 2'b11) ? "R4 walkPid" : "R3 walkPid",
          {44'd0, walkPid}, {44'd0, expPid});
    // R6 instruction flavour
    check(segIsInstr == (expSeg && isExec), "R6 segIsInstr",
          {63'd0, segIsInstr}, {63'd0, expSeg && isExec});
    // R7 data fault address (R11 zero otherwise)
    check(faultAddr == expFault, "R7 faultAddr", faultAddr, expFault);
    @(negedge clk);
    // R9 no response without a request
    check(rspValid == 1'b0, "R9 idle rspValid", {63'd0, rspValid}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] pats [3];
    logic [11:0] lps  [3];
    logic [19:0] pds  [3];
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF; lps[0] = 12'hFFF; pds[0] = 20'hFFFFF;
    pats[1] = 64'hA5A5_5A5A_0123_4567; lps[1] = 12'h3C1; pds[1] = 20'h9A5E3;
    pats[2] = 64'h5F00_0000_0000_1000; lps[2] = 12'h001; pds[2] = 20'h00002;

    rstN = 1'b0; reqValid = 1'b0; effAddr = '0; accType = 2'd0;
    instRelocOn = 1'b0; dataRelocOn = 1'b0; partIdReg = '0; procIdReg = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({rspValid, rspReal, rspWalk, rspSeg} == 4'b0000, "R10 reset flags",
          {60'd0, rspValid, rspReal, rspWalk, rspSeg}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R10 after reset", {63'd0, rspValid}, 64'd0);

    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 4; a++) begin
        for (int m = 0; m < 4; m++) begin
          for (int q = 0; q < 4; q++) begin
            runOne(2'(a), m[1], m[0], {2'(q), pats[p][61:0]}, lps[p], pds[p]);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule